// File: doc/BRIEF.md
# Four-Group Look-Ahead Carry Unit

This block works out, all at once, the carries for a row of four adder slices, or four groups of slices. Each group i supplies a generate and a propagate signal, both active-low, and the row as a whole receives one active-high carry-in. From these the block produces three things:

- the active-high carries into groups 1, 2 and 3;
- a group-level generate covering all four inputs;
- a group-level propagate covering all four inputs.

The two group-level signals are driven active-low. This is the same polarity the block accepts, so the pair from four such units can feed a fifth identical unit. That fifth unit then computes the carries between the four blocks, and the scheme repeats for longer words.

The block is purely combinational, with no clock, no register and no handshake. Its outputs follow its inputs within the same cycle. A stream interface with back-pressure does not apply here: the unit sits inside the datapath of whatever adder uses it. The number of groups is a parameter (`NGRP`, default 4). The requirements below are stated for the default.

Top module: `carry_lookahead4`

## Requirements
- R1: With active-low inputs (`g_n[i]`=0 means group i generates and `p_n[i]`=0 means group i propagates), `carry[0]` (the carry into group 1) is 1 exactly when group 0 generates, or when group 0 propagates and `cin`=1.
- R2: `carry[1]` (the carry into group 2) equals g1 | p1&g0 | p1&p0&cin, where gi and pi are the inverted inputs.
- R3: `carry[2]` (the carry into group 3) equals g2 | p2&g1 | p2&p1&g0 | p2&p1&p0&cin.
- R4: `grp_g_n` is 0 exactly when g3 | p3&g2 | p3&p2&g1 | p3&p2&p1&g0 holds.
- R5: `grp_p_n` is 0 exactly when all four `p_n` bits are 0. When that holds and `cin`=1, every carry output is 1.
- R6: `grp_g_n` and `grp_p_n` do not depend on `cin`.
- R7: Five units can be cascaded in two levels. Four first-level units each take the slice signals of four 4-bit adder slices, and a second-level unit takes the group outputs of those four units. The carries this cascade produces give the exact 64-bit sum. The carry-out of the whole word is ~`grp_g_n` | (~`grp_p_n` & `cin`) at the second-level unit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| g_n | input | NGRP | Per-group generate, active-low |
| p_n | input | NGRP | Per-group propagate, active-low |
| cin | input | 1 | Carry into group 0, active-high |
| carry | output | NGRP-1 | Carries into groups 1 to NGRP-1, active-high (bit 0 is the carry into group 1) |
| grp_g_n | output | 1 | Generate across all groups, active-low |
| grp_p_n | output | 1 | Propagate across all groups, active-low |

## Verification
The bench builds every unit with the default `NGRP` of 4. With that setting the single unit has only nine inputs, so all 512 input combinations are applied and compared with a ripple-carry reference computed in the bench. The same sweep compares the group outputs for the two `cin` values. Five default units are also wired as a two-level tree over sixteen 4-bit slices, and the sum and carry-out of that tree are compared with plain 65-bit arithmetic for corner and pseudo-random operands.

// File: rtl/lac_pkg.sv
package lac_pkg;

  localparam int unsigned LAC_MAX_GROUPS = 32;

  // AND of v[lo..hi]; an empty span (lo > hi) yields 1
  function automatic logic span_and(input logic [LAC_MAX_GROUPS-1:0] v,
                                    input int lo, input int hi);
    logic r;
    r = 1'b1;
    for (int k = 0; k < LAC_MAX_GROUPS; k++) begin
      if (k >= lo && k <= hi) r = r & v[k];
    end
    return r;
  endfunction

endpackage

// File: rtl/lac_invert.sv
module lac_invert #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  assign dout = ~din;
endmodule

// File: rtl/lac_carry_terms.sv
module lac_carry_terms
  import lac_pkg::*;
#(
  parameter int unsigned NGRP = 4
) (
  input  logic [NGRP-2:0] gen,
  input  logic [NGRP-2:0] prop,
  input  logic            cin,
  output logic [NGRP-2:0] cout
);
  localparam int unsigned NC = NGRP - 1;

  logic [LAC_MAX_GROUPS-1:0] gen_w, prop_w;
  assign gen_w  = LAC_MAX_GROUPS'(gen);
  assign prop_w = LAC_MAX_GROUPS'(prop);

  for (genvar i = 0; i < NC; i++) begin : g_carry
    // flattened sum of products for the carry into group i+1
    always_comb begin
      logic acc;
      acc = cin & span_and(prop_w, 0, i);
      for (int j = 0; j <= i; j++) begin
        acc = acc | (gen_w[j] & span_and(prop_w, j + 1, i));
      end
      cout[i] = acc;
    end
  end

  // R1
  always_comb begin
    if (gen[0]) begin
      // R1
      gen0_sets_cx_chk: assert (cout[0]);
    end
    if (cin && prop[0]) begin
      // R1
      cin_through_p0_chk: assert (cout[0]);
    end
  end

  for (genvar i = 0; i + 1 < NC; i++) begin : g_ripple_chk
    always_comb begin
      if (gen[i+1] || (prop[i+1] && cout[i])) begin
        // R2
        ripple_up_chk: assert (cout[i+1]);
      end else begin
        // R3
        ripple_down_chk: assert (!cout[i+1]);
      end
    end
  end
endmodule

// File: rtl/lac_group_terms.sv
module lac_group_terms
  import lac_pkg::*;
#(
  parameter int unsigned NGRP = 4
) (
  input  logic [NGRP-1:0] gen,
  input  logic [NGRP-1:0] prop,
  output logic            grp_gen,
  output logic            grp_prop
);
  localparam int unsigned TOP = NGRP - 1;

  logic [LAC_MAX_GROUPS-1:0] gen_w, prop_w;
  assign gen_w  = LAC_MAX_GROUPS'(gen);
  assign prop_w = LAC_MAX_GROUPS'(prop);

  always_comb begin
    logic acc;
    acc = 1'b0;
    for (int j = 0; j < NGRP; j++) begin
      acc = acc | (gen_w[j] & span_and(prop_w, j + 1, TOP));
    end
    grp_gen  = acc;
    grp_prop = span_and(prop_w, 0, TOP);
  end

  always_comb begin
    if (gen[TOP]) begin
      // R4
      top_gen_sets_grp_chk: assert (grp_gen);
    end
    if (!gen[0] && !gen[TOP]) begin
      // R4
      no_top_gen_no_prop_chk: assert (prop[TOP] || !grp_gen);
    end
  end
endmodule

// File: rtl/carry_lookahead4.sv
module carry_lookahead4 #(
  parameter int unsigned NGRP = 4
) (
  input  logic [NGRP-1:0] g_n,
  input  logic [NGRP-1:0] p_n,
  input  logic            cin,
  output logic [NGRP-2:0] carry,
  output logic            grp_g_n,
  output logic            grp_p_n
);
  logic [NGRP-1:0] gen, prop;
  logic            grp_gen, grp_prop;

  lac_invert #(.WIDTH(NGRP)) u_inv_g (.din(g_n), .dout(gen));
  lac_invert #(.WIDTH(NGRP)) u_inv_p (.din(p_n), .dout(prop));

  lac_carry_terms #(.NGRP(NGRP)) u_carry (
    .gen  (gen[NGRP-2:0]),
    .prop (prop[NGRP-2:0]),
    .cin  (cin),
    .cout (carry)
  );

  lac_group_terms #(.NGRP(NGRP)) u_group (
    .gen      (gen),
    .prop     (prop),
    .grp_gen  (grp_gen),
    .grp_prop (grp_prop)
  );

  lac_invert #(.WIDTH(2)) u_inv_out (
    .din  ({grp_gen, grp_prop}),
    .dout ({grp_g_n, grp_p_n})
  );

  always_comb begin
    if (!grp_p_n && cin) begin
      // R5
      full_prop_chk: assert (&carry);
    end
    if (!grp_p_n) begin
      // R5
      grp_p_low_chk: assert (p_n == '0);
    end
  end
endmodule

// File: tb/test_carry_lookahead4.sv
module test_carry_lookahead4;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic chk(input bit ok, input string req,
                     input logic [64:0] act, input logic [64:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- single unit ----------------
  logic [3:0] g_n, p_n;
  logic       cin;
  logic [2:0] carry;
  logic       grp_g_n, grp_p_n;

  carry_lookahead4 i_carry_lookahead4 (
    .g_n(g_n), .p_n(p_n), .cin(cin),
    .carry(carry), .grp_g_n(grp_g_n), .grp_p_n(grp_p_n)
  );

  // ripple reference: {grp_p_n, grp_g_n, carry[2:0]}
  function automatic logic [4:0] ref_unit(input logic [8:0] v);
    logic [3:0] g, p;
    logic c, gg;
    logic [2:0] cc;
    g = ~v[3:0];
    p = ~v[7:4];
    c = v[8];
    for (int i = 0; i < 3; i++) begin
      c = g[i] | (p[i] & c);
      cc[i] = c;
    end
    gg = 1'b0;
    for (int i = 0; i < 4; i++) gg = g[i] | (p[i] & gg);
    return {~(&p), ~gg, cc};
  endfunction

  // ---------------- two-level cascade ----------------
  logic [63:0] a, b;
  logic        ccin;
  logic [15:0] sg_n, sp_n, sc;
  logic [63:0] sum_w;
  logic [3:0]  l1_cin, l1_gg_n, l1_gp_n;
  logic [2:0]  l1_c [4];
  logic [2:0]  l2_c;
  logic        l2_gg_n, l2_gp_n;

  for (genvar s = 0; s < 16; s++) begin : g_slice
    logic [4:0] raw;
    assign raw     = {1'b0, a[4*s+3:4*s]} + {1'b0, b[4*s+3:4*s]};
    assign sg_n[s] = ~(raw > 5'd15);
    assign sp_n[s] = ~(raw >= 5'd15);
    assign sum_w[4*s+3:4*s] = a[4*s+3:4*s] + b[4*s+3:4*s] + {3'b000, sc[s]};
  end

  for (genvar k = 0; k < 4; k++) begin : g_lvl1
    if (k == 0) begin : g_first
      assign l1_cin[k] = ccin;
    end else begin : g_rest
      assign l1_cin[k] = l2_c[k-1];
    end
    assign sc[4*k] = l1_cin[k];
    assign sc[4*k+3:4*k+1] = l1_c[k];
    carry_lookahead4 i_lvl1 (
      .g_n(sg_n[4*k+3:4*k]), .p_n(sp_n[4*k+3:4*k]), .cin(l1_cin[k]),
      .carry(l1_c[k]), .grp_g_n(l1_gg_n[k]), .grp_p_n(l1_gp_n[k])
    );
  end

  carry_lookahead4 i_lvl2 (
    .g_n(l1_gg_n), .p_n(l1_gp_n), .cin(ccin),
    .carry(l2_c), .grp_g_n(l2_gg_n), .grp_p_n(l2_gp_n)
  );

  task automatic run_cascade(input logic [63:0] va, input logic [63:0] vb,
                             input logic vc);
    logic [64:0] exp, act;
    @(posedge clk);
    a = va; b = vb; ccin = vc;
    @(negedge clk);
    exp = {1'b0, va} + {1'b0, vb} + {64'd0, vc};
    act = {(~l2_gg_n) | ((~l2_gp_n) & vc), sum_w};
    chk(act == exp, "R7 cascade sum", act, exp);
  endtask

  logic [4:0] grp_seen [256];

  initial begin
    logic [63:0] lf;
    g_n = '1; p_n = '1; cin = 1'b0;
    a = '0; b = '0; ccin = 1'b0;
    @(negedge clk);
    // idle inputs: nothing generates or propagates
    chk({carry, grp_g_n, grp_p_n} == 5'b00011, "R1 idle state",
        65'({carry, grp_g_n, grp_p_n}), 65'(5'b00011));

    // exhaustive sweep: v = {cin, p_n, g_n}
    for (int v = 0; v < 512; v++) begin
      logic [4:0] e, got;
      @(posedge clk);
      {cin, p_n, g_n} = 9'(v);
      @(negedge clk);
      e   = ref_unit(9'(v));
      got = {grp_p_n, grp_g_n, carry};
      chk(got[0] == e[0], "R1 carry into group1", 65'(got[0]), 65'(e[0]));
      chk(got[1] == e[1], "R2 carry into group2", 65'(got[1]), 65'(e[1]));
      chk(got[2] == e[2], "R3 carry into group3", 65'(got[2]), 65'(e[2]));
      chk(got[3] == e[3], "R4 group generate", 65'(got[3]), 65'(e[3]));
      chk(got[4] == e[4], "R5 group propagate", 65'(got[4]), 65'(e[4]));
      if (v < 256) grp_seen[v] = got;
      else chk(got[4:3] == grp_seen[v-256][4:3], "R6 group outputs vs cin",
               65'(got[4:3]), 65'(grp_seen[v-256][4:3]));
    end

    // R5 boundary: everything propagates, carry-in set
    @(posedge clk);
    g_n = '1; p_n = '0; cin = 1'b1;
    @(negedge clk);
    chk({carry, grp_p_n} == 4'b1110, "R5 full propagate chain",
        65'({carry, grp_p_n}), 65'(4'b1110));

    // cascade corners
    run_cascade('1, '0, 1'b1);
    run_cascade('1, 64'd1, 1'b0);
    run_cascade('0, '0, 1'b0);
    run_cascade('0, '0, 1'b1);
    run_cascade('1, '1, 1'b1);
    run_cascade(64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAA, 1'b1);
    run_cascade(64'h0000_FFFF_0000_FFFF, 64'h0000_0001_0000_0001, 1'b0);
    lf = 64'h9E37_79B9_7F4A_7C15;
    for (int n = 0; n < 60; n++) begin
      logic [63:0] x;
      lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]};
      x  = lf ^ {lf[31:0], lf[63:32]};
      run_cascade(lf, x, lf[5]);
    end

    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    end
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule